// File: doc/BRIEF.md
# Configurable-Mode SPI Shift Controller

This block is a single-target SPI master. Each write to its 32-bit transmit word starts one full-duplex transfer of between 1 and 32 bits. Outgoing bits are taken from the top of the transmit word, most significant bit first. Incoming bits are collected into a right-justified receive word, and a receive-full flag reports that a result is waiting.

An 8-bit configuration word and an 8-bit divider set the following:
- the resting level of the serial clock;
- which clock edge captures incoming data and which one changes outgoing data;
- a chip-select line driven under software control;
- the transfer length;
- the serial clock rate.

The configuration, the divider and the transfer length are captured when a transfer starts. Software chooses a target by raising the chip-select field, and writes the transmit word to start a transfer. It waits for the receive-full flag, then reads the result and pulses the read strobe to clear the flag.

Top module: `spi_shift_ctrl`

## Requirements
- R1: The configuration word is laid out as follows: bit 0 is the clock rest level, bit 1 is the edge select, bit 2 is the chip-select request, and bits 7:3 hold a length code L. The transfer moves N = L+1 bits, so L = 31 gives 32 bits.
- R2: While no transfer runs, `sck_o` equals configuration bit 0 as registered one clock earlier. After the last edge of a transfer it is back at that transfer's rest level.
- R3: With edge select 0, `miso_i` is captured on rising edges of `sck_o` and `mosi_o` changes on falling edges. With edge select 1, `mosi_o` changes on rising edges and `miso_i` is captured on falling edges. In both cases the first bit is on `mosi_o` before the first capturing edge.
- R4: `cs_n_o` is the inverse of configuration bit 2, registered one clock later. It is 0 (selected) when bit 2 is 1.
- R5: An N-bit transfer produces exactly 2N edges on `sck_o`.
- R6: Each half period of `sck_o` lasts 2*D system clocks, where D is the divider value. A divider of 0 behaves as 1.
- R7: The transmit word is sent from bit 31 downward, so an N-bit transfer sends bits [31:32-N].
- R8: `rx_data_o` changes only at the completion of a transfer. It then holds the N received bits in bits [N-1:0], first-received bit highest, and zeros above them.
- R9: `rx_full_o` goes to 1 one clock after a transfer completes and stays 1 until a cycle with `rx_rd_i` high clears it. A completion in the same cycle as a read leaves it at 1.
- R10: A pulse on `tx_wr_i` while a transfer is running has no effect on that transfer or its result.
- R11: After reset, `sck_o` is 0, `cs_n_o` is 1, `rx_full_o` is 0 and `rx_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_i | input | 8 | Configuration word: rest level, edge select, chip-select request, length code |
| div_i | input | 8 | Clock divider; the half period is 2*div_i clocks |
| tx_data_i | input | 32 | Left-justified transmit word |
| tx_wr_i | input | 1 | One-clock write strobe that starts a transfer when idle |
| rx_rd_i | input | 1 | Read strobe that clears the receive-full flag |
| miso_i | input | 1 | Serial data from the target |
| rx_data_o | output | 32 | Right-justified received word |
| rx_full_o | output | 1 | A completed result is waiting to be read |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the target |
| cs_n_o | output | 1 | Active-low chip select |

## Verification
Errors in the internal state show up at the pins as soon as the affected edge occurs:
- A wrong edge counter shows up as a wrong number of `sck_o` edges before `rx_full_o` rises.
- An inverted capture or launch choice makes the receive word or the target's captured bits differ from the expected slice within one transfer.
- A wrong divider count shows up as a wrong gap between the first two clock edges.
- A flag or result register that updates at the wrong time is seen within one clock of completion or of a read.

The bench sweeps all four clock modes and every length from 1 to 32 against a target model driven from the pins. It also sweeps the divider down to 0 and up to its maximum.

// File: rtl/spi_shift_pkg.sv
// Package spi_shift_pkg
// Shared constants and types for the SPI shift controller.
// Assumes a 5-bit length code, which fixes the data word at 32 bits.
package spi_shift_pkg;

    localparam int unsigned SPI_LEN_W  = 5;
    localparam int unsigned SPI_DATA_W = 2 ** SPI_LEN_W;

    // Configuration word; the first field takes the top bits.
    typedef struct packed {
        logic [SPI_LEN_W-1:0] len_code;   // bits 7:3, transfer length minus one
        logic                 cs_req;     // bit 2, request chip select
        logic                 edge_sel;   // bit 1, capture/launch edge choice
        logic                 rest_lvl;   // bit 0, serial clock level when idle
    } spi_cfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/spi_tick_gen.sv
// Module spi_tick_gen
// Emits a one-clock tick every 2*div clocks while enabled, and restarts
// its count whenever the enable is low. Assumes the divider is held stable
// while enabled. A divider of 0 is treated as 1.
module spi_tick_gen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int unsigned CNT_W = DIV_W + 1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [DIV_W-1:0] div_eff;
    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] cnt_q;

    // Clamp the divider and form the last count of a half period.
    always_comb begin
        div_eff = (div == '0) ? DIV_W'(1) : div;
        half_m1 = {div_eff, 1'b0} - CNT_ONE;
    end

    // Count clocks within one half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == half_m1) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign tick = en && (cnt_q == half_m1);

endmodule

// File: rtl/spi_bit_seq.sv
// Module spi_bit_seq
// Sequences one transfer. It captures the mode and the length at start,
// toggles the serial clock on each tick and counts the edges. It flags
// which edges capture input and which edges launch output.
// Assumes start is only raised while the block reports not running.
module spi_bit_seq
    import spi_shift_pkg::*;
#(
    parameter int unsigned LEN_W = SPI_LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rest_lvl,
    input  logic             edge_sel,
    input  logic [LEN_W-1:0] len_code,
    input  logic             tick,
    output logic             running,
    output logic             tick_en,
    output logic             sck,
    output logic             do_sample,
    output logic             do_launch,
    output logic             xfer_done
);
    localparam int unsigned TGL_W = LEN_W + 1;
    localparam logic [TGL_W-1:0] TGL_ONE = TGL_W'(1);

    seq_state_t       st_q;
    logic [TGL_W-1:0] tgl_q;
    logic             rest_q;
    logic             edge_q;
    logic [LEN_W-1:0] len_q;
    logic             sck_q;

    logic is_lead;
    logic sample_lead;
    logic first_bit;
    logic last_tgl;

    // Classify the edge that the next tick will produce.
    always_comb begin
        is_lead     = ~tgl_q[0];
        sample_lead = (edge_q == rest_q);
        first_bit   = (tgl_q[TGL_W-1:1] == '0);
        last_tgl    = (tgl_q == {len_q, 1'b1});
        do_sample   = tick && (is_lead == sample_lead);
        do_launch   = tick && (is_lead != sample_lead) && !(is_lead && first_bit);
    end

    // Step the transfer state, the edge count and the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SEQ_IDLE;
            tgl_q  <= '0;
            rest_q <= 1'b0;
            edge_q <= 1'b0;
            len_q  <= '0;
            sck_q  <= 1'b0;
        end else begin
            case (st_q)
                SEQ_IDLE: begin
                    sck_q <= rest_lvl;
                    if (start) begin
                        st_q   <= SEQ_RUN;
                        tgl_q  <= '0;
                        rest_q <= rest_lvl;
                        edge_q <= edge_sel;
                        len_q  <= len_code;
                    end
                end
                SEQ_RUN: begin
                    if (tick) begin
                        sck_q <= ~sck_q;
                        tgl_q <= tgl_q + TGL_ONE;
                        if (last_tgl) begin
                            st_q <= SEQ_DONE;
                        end
                    end
                end
                default: begin
                    st_q <= SEQ_IDLE;
                end
            endcase
        end
    end

    assign running   = (st_q != SEQ_IDLE);
    assign tick_en   = (st_q == SEQ_RUN);
    assign xfer_done = (st_q == SEQ_DONE);
    assign sck       = sck_q;

endmodule

// File: rtl/spi_shift_path.sv
// Module spi_shift_path
// Holds the outgoing and incoming shift registers, the result register
// and the receive-full flag. Assumes load, sample and launch are mutually
// exclusive, and that the done pulse lasts one clock.
module spi_shift_path #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] tx_word,
    input  logic          do_sample,
    input  logic          do_launch,
    input  logic          miso,
    input  logic          xfer_done,
    input  logic          rx_rd,
    output logic          mosi,
    output logic [DW-1:0] rx_word,
    output logic          rx_full
);
    logic [DW-1:0] txs_q;
    logic [DW-1:0] rxs_q;
    logic [DW-1:0] rxw_q;
    logic          full_q;

    // Outgoing register: load at start, move up one place per launch edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txs_q <= '0;
        end else if (load) begin
            txs_q <= tx_word;
        end else if (do_launch) begin
            txs_q <= {txs_q[DW-2:0], 1'b0};
        end
    end

    // Incoming register: clear at start, shift in one bit per capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxs_q <= '0;
        end else if (load) begin
            rxs_q <= '0;
        end else if (do_sample) begin
            rxs_q <= {rxs_q[DW-2:0], miso};
        end
    end

    // Result register and flag: set on completion, flag cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxw_q  <= '0;
            full_q <= 1'b0;
        end else if (xfer_done) begin
            rxw_q  <= rxs_q;
            full_q <= 1'b1;
        end else if (rx_rd) begin
            full_q <= 1'b0;
        end
    end

    assign mosi    = txs_q[DW-1];
    assign rx_word = rxw_q;
    assign rx_full = full_q;

endmodule

// File: rtl/spi_shift_ctrl.sv
// Module spi_shift_ctrl
// Single-target SPI master with a programmable clock mode, length and rate.
// A write while idle starts one transfer; writes during a transfer are
// dropped. Assumes the inputs are synchronous to clk.
module spi_shift_ctrl
    import spi_shift_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            cfg_i,
    input  logic [DIV_W-1:0]      div_i,
    input  logic [SPI_DATA_W-1:0] tx_data_i,
    input  logic                  tx_wr_i,
    input  logic                  rx_rd_i,
    input  logic                  miso_i,
    output logic [SPI_DATA_W-1:0] rx_data_o,
    output logic                  rx_full_o,
    output logic                  sck_o,
    output logic                  mosi_o,
    output logic                  cs_n_o
);
    spi_cfg_t         cfg_s;
    logic [DIV_W-1:0] div_q;
    logic             cs_n_q;
    logic             running;
    logic             tick_en;
    logic             tick;
    logic             do_sample;
    logic             do_launch;
    logic             xfer_done;
    logic             start;

    assign cfg_s = spi_cfg_t'(cfg_i);
    assign start = tx_wr_i && !running;

    // Chip select follows the configuration request, one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
        end else begin
            cs_n_q <= ~cfg_s.cs_req;
        end
    end

    // Capture the divider when a transfer starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(1);
        end else if (start) begin
            div_q <= div_i;
        end
    end

    spi_tick_gen #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tick_en),
        .div   (div_q),
        .tick  (tick)
    );

    spi_bit_seq #(
        .LEN_W (SPI_LEN_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rest_lvl  (cfg_s.rest_lvl),
        .edge_sel  (cfg_s.edge_sel),
        .len_code  (cfg_s.len_code),
        .tick      (tick),
        .running   (running),
        .tick_en   (tick_en),
        .sck       (sck_o),
        .do_sample (do_sample),
        .do_launch (do_launch),
        .xfer_done (xfer_done)
    );

    spi_shift_path #(
        .DW (SPI_DATA_W)
    ) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .tx_word   (tx_data_i),
        .do_sample (do_sample),
        .do_launch (do_launch),
        .miso      (miso_i),
        .xfer_done (xfer_done),
        .rx_rd     (rx_rd_i),
        .mosi      (mosi_o),
        .rx_word   (rx_data_o),
        .rx_full   (rx_full_o)
    );

    assign cs_n_o = cs_n_q;

endmodule

// File: rtl/spi_shift_ctrl_chk.sv
// Module spi_shift_ctrl_chk
// Temporal checks on the SPI shift controller, bound to the top module.
// Assumes rst_n is held low for at least one clock at time zero.
module spi_shift_ctrl_chk #(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_rest,
    input logic          cfg_cs,
    input logic          rx_rd_i,
    input logic          rx_full_o,
    input logic [DW-1:0] rx_data_o,
    input logic          sck_o,
    input logic          cs_n_o,
    input logic          running,
    input logic          xfer_done
);

    AST_CS_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cs_n_o == !$past(cfg_cs))); // R4

    AST_SCK_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !running && $past(!running)) |-> (sck_o == $past(cfg_rest))); // R2

    AST_FULL_SET_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> rx_full_o); // R9

    AST_FULL_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_i && !xfer_done) |=> !rx_full_o); // R9

    AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(rx_data_o)) |-> $past(xfer_done)); // R8

endmodule

bind spi_shift_ctrl spi_shift_ctrl_chk #(.DW(spi_shift_pkg::SPI_DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rest  (cfg_i[0]),
    .cfg_cs    (cfg_i[2]),
    .rx_rd_i   (rx_rd_i),
    .rx_full_o (rx_full_o),
    .rx_data_o (rx_data_o),
    .sck_o     (sck_o),
    .cs_n_o    (cs_n_o),
    .running   (running),
    .xfer_done (xfer_done)
);

// File: tb/spi_shift_ctrl_tb.sv
// Bench spi_shift_ctrl_tb
// Sweeps every clock mode and length against a pin-level target model,
// then sweeps the divider, and checks that a write during a transfer is
// dropped. Expected values come from shifts of the stimulus words.
module spi_shift_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cfg_i;
    logic [7:0]  div_i;
    logic [31:0] tx_data_i;
    logic        tx_wr_i;
    logic        rx_rd_i;
    logic        miso_i;
    logic [31:0] rx_data_o;
    logic        rx_full_o;
    logic        sck_o;
    logic        mosi_o;
    logic        cs_n_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // target model state
    logic [31:0] s_tx;
    logic [31:0] s_rx;
    logic        s_first;
    logic        sck_prev = 1'b0;
    int          edges;
    int          t0;
    int          t1;
    logic        t_rest;
    logic        t_edge;

    spi_shift_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_i     (cfg_i),
        .div_i     (div_i),
        .tx_data_i (tx_data_i),
        .tx_wr_i   (tx_wr_i),
        .rx_rd_i   (rx_rd_i),
        .miso_i    (miso_i),
        .rx_data_o (rx_data_o),
        .rx_full_o (rx_full_o),
        .sck_o     (sck_o),
        .mosi_o    (mosi_o),
        .cs_n_o    (cs_n_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Target model, acting away from the active clock edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sck_o !== sck_prev) begin
                if (cs_n_o === 1'b0) begin
                    logic lead;
                    logic smp;
                    lead = (sck_prev == t_rest);
                    smp  = (lead == (t_edge == t_rest));
                    if (edges == 0) t0 = cyc;
                    if (edges == 1) t1 = cyc;
                    edges++;
                    if (smp) begin
                        s_rx = {s_rx[30:0], mosi_o};
                    end else if (!(lead && s_first)) begin
                        s_tx   = s_tx << 1;
                        miso_i = s_tx[31];
                    end
                    if (lead) s_first = 1'b0;
                end
                sck_prev = sck_o;
            end
        end
    end

    task automatic run_xfer(input bit rest, input bit edg, input int n, input int dv,
                            input logic [31:0] txw, input logic [31:0] pat,
                            input bit poke, input bit chk_half);
        int k;
        logic [31:0] exp_rx;
        logic [31:0] exp_tgt;
        int half;
        t_rest = rest;
        t_edge = edg;
        cfg_i  = {5'(n - 1), 1'b0, edg, rest};
        div_i  = 8'(dv);
        repeat (3) @(negedge clk);
        chk(sck_o == rest, "R2 rest level before transfer", {31'd0, sck_o}, {31'd0, rest});
        cfg_i[2] = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n_o == 1'b0, "R4 select asserted", {31'd0, cs_n_o}, 32'd0);
        s_tx    = pat;
        miso_i  = pat[31];
        s_rx    = '0;
        s_first = 1'b1;
        edges   = 0;
        tx_data_i = txw;
        tx_wr_i   = 1'b1;
        @(negedge clk);
        tx_wr_i   = 1'b0;
        tx_data_i = '0;
        if (poke) begin
            repeat (3) @(negedge clk);
            tx_data_i = ~txw;
            tx_wr_i   = 1'b1;
            @(negedge clk);
            tx_wr_i   = 1'b0;
        end
        k = 0;
        while (!rx_full_o && k < 40000) begin
            @(negedge clk);
            k++;
        end
        chk(k < 40000, "R9 completion flag timeout", {31'd0, rx_full_o}, 32'd1);
        exp_rx  = pat >> (32 - n);
        exp_tgt = txw >> (32 - n);
        chk(rx_data_o == exp_rx, poke ? "R10 result kept after dropped write" : "R1/R3/R8 received word",
            rx_data_o, exp_rx);
        chk(s_rx == exp_tgt, poke ? "R10 sent bits kept after dropped write" : "R7 bits seen by target",
            s_rx, exp_tgt);
        chk(edges == 2 * n, "R5 clock edge count", 32'(edges), 32'(2 * n));
        if (chk_half) begin
            half = 2 * ((dv == 0) ? 1 : dv);
            chk((t1 - t0) == half, "R6 half period", 32'(t1 - t0), 32'(half));
        end
        repeat (4) @(negedge clk);
        chk(rx_full_o == 1'b1, "R9 flag held until read", {31'd0, rx_full_o}, 32'd1);
        chk(sck_o == rest, "R2 rest level after transfer", {31'd0, sck_o}, {31'd0, rest});
        rx_rd_i = 1'b1;
        @(negedge clk);
        rx_rd_i = 1'b0;
        chk(rx_full_o == 1'b0, "R9 flag cleared by read", {31'd0, rx_full_o}, 32'd0);
        cfg_i[2] = 1'b0;
        repeat (2) @(negedge clk);
        chk(cs_n_o == 1'b1, "R4 select released", {31'd0, cs_n_o}, 32'd1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_i = '0;
        div_i = 8'd1;
        tx_data_i = '0;
        tx_wr_i = 1'b0;
        rx_rd_i = 1'b0;
        miso_i = 1'b0;
        t_rest = 1'b0;
        t_edge = 1'b0;
        edges = 0;
        t0 = 0;
        t1 = 0;
        s_tx = '0;
        s_rx = '0;
        s_first = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sck_o == 1'b0, "R11 reset clock", {31'd0, sck_o}, 32'd0);
        chk(cs_n_o == 1'b1, "R11 reset select", {31'd0, cs_n_o}, 32'd1);
        chk(rx_full_o == 1'b0, "R11 reset flag", {31'd0, rx_full_o}, 32'd0);
        chk(rx_data_o == 32'd0, "R11 reset result", rx_data_o, 32'd0);

        // R1 R3 R5 R7 R8: every mode and every length
        for (int m = 0; m < 4; m++) begin
            for (int n = 1; n <= 32; n++) begin
                logic [31:0] txw;
                logic [31:0] pat;
                txw = 32'hA5C3_0F96 ^ (32'(n) * 32'h9E37_79B1) ^ (32'(m) << 7);
                pat = ~{txw[12:0], txw[31:13]} ^ 32'(m * 3 + n);
                run_xfer(m[0], m[1], n, (n % 3 == 0) ? 2 : 1, txw, pat, 1'b0, 1'b0);
            end
        end

        // R6: divider sweep including 0 and the maximum
        begin
            int dvs[6] = '{0, 1, 2, 3, 7, 255};
            for (int i = 0; i < 6; i++) begin
                run_xfer(1'b1, 1'b0, 3, dvs[i], 32'hC000_0000 ^ 32'(i << 29), 32'h6000_0000, 1'b0, 1'b1);
            end
        end

        // R10: write during a transfer is dropped
        run_xfer(1'b0, 1'b1, 16, 2, 32'h1234_5678, 32'hBEEF_0000, 1'b1, 1'b0);
        run_xfer(1'b1, 1'b1, 32, 1, 32'h8000_0001, 32'h7FFF_FFFE, 1'b1, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule